// File: doc/BRIEF.md
# Successive Approximation Conversion Controller

This block is the digital half of a successive-approximation analog-to-digital converter. A start request opens a conversion. The block first holds a sample phase of fixed length, during which the external sample/hold stage captures the input. It then runs a binary search over the result bits, one bit per trial. For each trial it drives a trial code to an external DAC. It reads back a one-bit comparator decision, which is high when the held input is above the DAC level for that code.

When the last trial has been made, the block latches the result and pulses a completion strobe. Every step waits for a clock-enable input, so an external prescaler sets the converter rate. The analog parts and channel selection sit outside this block.

Top module: `sar_adc_ctrl`

## Requirements
- R1: On the first trial after the sample phase, `dac_code` holds only its most significant bit set (0x80 for the default 8-bit width).
- R2: After each trial, the tested bit stays 1 if `cmp_in` was 1 (input above the trial code) and becomes 0 otherwise. The next lower bit is then set for the following trial.
- R3: A conversion makes exactly DATA_W trials, from the top bit down to bit 0. The result is the largest code below the held input, and it saturates at all ones for inputs above the top code.
- R4: From the enabled edge that accepts `start` to the edge that produces `done`, exactly SAMPLE_CYCLES + DATA_W enabled edges pass, whatever the input value.
- R5: `sample_hold` is high for exactly SAMPLE_CYCLES enabled cycles immediately after acceptance, and `dac_code` reads 0 during that phase.
- R6: `done` is high for exactly one clock cycle, `busy` is low in that cycle, and `result` already holds the new value.
- R7: A `start` seen while `busy` is high has no effect on timing or result.
- R8: `result` changes only in the cycle in which `done` is high. It stays stable through the following conversion until that conversion ends.
- R9: State advances only on clock edges where `clk_en` is high. A `start` is accepted only on such an edge.
- R10: After reset, `busy`, `done`, `sample_hold`, `dac_code` and `result` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clk_en | input | 1 | Converter step enable from a prescaler |
| start | input | 1 | Conversion request |
| cmp_in | input | 1 | Comparator decision: 1 when the input is above the DAC level |
| sample_hold | output | 1 | High while the sample/hold stage should track the input |
| dac_code | output | DATA_W | Trial code for the external DAC |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle completion strobe |
| result | output | DATA_W | Latched conversion result |

## Verification
The held input is swept over directed values: zero, one, the midpoint, the top code, one past the top, and far above the range. These values separate a correct strict-greater decision from an off-by-one decision, and they show whether the result saturates. Random inputs at several enable periods show that the bit decisions are right across the code space. They also show that the conversion length tracks the number of enabled edges and not the number of clocks. Runs with extra start pulses in the middle of a conversion tell a controller that ignores restarts apart from one that restarts or stretches.

// File: rtl/sar_pkg.sv
// Shared types for the successive approximation controller.
// Assumes nothing beyond a single clock domain.
package sar_pkg;
    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SAMPLE = 2'd1,
        PH_TRIAL  = 2'd2
    } sar_phase_e;
endpackage

// File: rtl/sar_phase_ctrl.sv
// Phase sequencer: idle, fixed sample phase, then one trial per bit.
// Assumes SAMPLE_CYCLES >= 1 and DATA_W >= 2. Every move waits on clk_en.
module sar_phase_ctrl
    import sar_pkg::*;
#(
    parameter int DATA_W        = 8,
    parameter int SAMPLE_CYCLES = 2,
    localparam int IDX_W        = $clog2(DATA_W),
    localparam int CNT_W        = $clog2(SAMPLE_CYCLES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clk_en,
    input  logic             start,
    output sar_phase_e       phase,
    output logic             accept,
    output logic             load_msb,
    output logic             step,
    output logic [IDX_W-1:0] bit_idx,
    output logic             last
);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(SAMPLE_CYCLES - 1);
    localparam logic [IDX_W-1:0] IDX_TOP  = IDX_W'(DATA_W - 1);

    logic [CNT_W-1:0] samp_cnt;

    // Decode the one-cycle control strobes for the register stage
    always_comb begin
        accept   = clk_en && start && (phase == PH_IDLE);
        load_msb = clk_en && (phase == PH_SAMPLE) && (samp_cnt == LAST_CNT);
        step     = clk_en && (phase == PH_TRIAL);
        last     = (bit_idx == '0);
    end

    // Phase, sample counter and bit index update on enabled edges
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= PH_IDLE;
            samp_cnt <= '0;
            bit_idx  <= '0;
        end else begin
            case (phase)
                PH_IDLE: begin
                    if (accept) begin
                        phase    <= PH_SAMPLE;
                        samp_cnt <= '0;
                    end
                end
                PH_SAMPLE: begin
                    if (clk_en) begin
                        if (samp_cnt == LAST_CNT) begin
                            phase   <= PH_TRIAL;
                            bit_idx <= IDX_TOP;
                        end else begin
                            samp_cnt <= samp_cnt + 1'b1;
                        end
                    end
                end
                PH_TRIAL: begin
                    if (clk_en) begin
                        if (last) begin
                            phase <= PH_IDLE;
                        end else begin
                            bit_idx <= bit_idx - 1'b1;
                        end
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/sar_trial_reg.sv
// Trial register and result latch. Applies each comparator decision to
// the bit under test and latches the final code with a one-cycle strobe.
// Assumes strobes come from sar_phase_ctrl and are already gated by clk_en.
module sar_trial_reg #(
    parameter int DATA_W = 8,
    localparam int IDX_W = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              load_msb,
    input  logic              step,
    input  logic [IDX_W-1:0]  bit_idx,
    input  logic              last,
    input  logic              cmp_in,
    output logic [DATA_W-1:0] trial,
    output logic [DATA_W-1:0] result,
    output logic              done
);
    localparam logic [DATA_W-1:0] MSB_ONLY = {1'b1, {(DATA_W-1){1'b0}}};

    // Trial code: clear on accept, seed the top bit, then resolve bit by bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trial <= '0;
        end else if (accept) begin
            trial <= '0;
        end else if (load_msb) begin
            trial <= MSB_ONLY;
        end else if (step) begin
            trial[bit_idx] <= cmp_in;
            if (!last) begin
                trial[bit_idx - 1'b1] <= 1'b1;
            end
        end
    end

    // Result latch and completion strobe on the final trial
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result <= '0;
            done   <= 1'b0;
        end else begin
            done <= step && last;
            if (step && last) begin
                result <= {trial[DATA_W-1:1], cmp_in};
            end
        end
    end
endmodule

// File: rtl/sar_adc_ctrl.sv
// Top of the successive approximation controller. Joins the phase
// sequencer and the trial register and decodes the phase outputs.
// Assumes the external DAC and comparator settle within one enabled step.
module sar_adc_ctrl
    import sar_pkg::*;
#(
    parameter int DATA_W        = 8,
    parameter int SAMPLE_CYCLES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_en,
    input  logic              start,
    input  logic              cmp_in,
    output logic              sample_hold,
    output logic [DATA_W-1:0] dac_code,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] result
);
    localparam int IDX_W = $clog2(DATA_W);

    sar_phase_e       phase;
    logic             accept;
    logic             load_msb;
    logic             step;
    logic             last;
    logic [IDX_W-1:0] bit_idx;

    sar_phase_ctrl #(
        .DATA_W        (DATA_W),
        .SAMPLE_CYCLES (SAMPLE_CYCLES)
    ) u_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .clk_en   (clk_en),
        .start    (start),
        .phase    (phase),
        .accept   (accept),
        .load_msb (load_msb),
        .step     (step),
        .bit_idx  (bit_idx),
        .last     (last)
    );

    sar_trial_reg #(
        .DATA_W (DATA_W)
    ) u_reg (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (accept),
        .load_msb (load_msb),
        .step     (step),
        .bit_idx  (bit_idx),
        .last     (last),
        .cmp_in   (cmp_in),
        .trial    (dac_code),
        .result   (result),
        .done     (done)
    );

    // Decode externally visible phase flags
    always_comb begin
        sample_hold = (phase == PH_SAMPLE);
        busy        = (phase != PH_IDLE);
    end
endmodule

// File: rtl/sar_adc_ctrl_chk.sv
// Checker for sar_adc_ctrl, attached by bind. Watches only top-level ports
// and counts enabled edges itself to check phase lengths.
module sar_adc_ctrl_chk #(
    parameter int DATA_W        = 8,
    parameter int SAMPLE_CYCLES = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              clk_en,
    input logic              start,
    input logic              cmp_in,
    input logic              sample_hold,
    input logic [DATA_W-1:0] dac_code,
    input logic              busy,
    input logic              done,
    input logic [DATA_W-1:0] result
);
    localparam int TOTAL = SAMPLE_CYCLES + DATA_W;
    localparam logic [DATA_W-1:0] MSB_ONLY = {1'b1, {(DATA_W-1){1'b0}}};

    int unsigned busy_cnt;
    int unsigned samp_cnt;

    // Count enabled edges seen while busy
    always_ff @(posedge clk) begin
        if (!rst_n || !busy) busy_cnt <= 0;
        else if (clk_en)     busy_cnt <= busy_cnt + 1;
    end

    // Count enabled edges seen while sampling
    always_ff @(posedge clk) begin
        if (!rst_n || !sample_hold) samp_cnt <= 0;
        else if (clk_en)            samp_cnt <= samp_cnt + 1;
    end

    a_r1_msb_first: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(sample_hold) && busy) |-> (dac_code == MSB_ONLY));

    a_r4_fixed_length: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (busy_cnt == TOTAL));

    a_r5_sample_len: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(sample_hold) && busy) |-> (samp_cnt == SAMPLE_CYCLES));

    a_r5_code_zero_sampling: assert property (@(posedge clk) disable iff (!rst_n)
        sample_hold |-> (dac_code == '0));

    a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r6_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    a_r8_result_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(result));

    a_r9_hold_without_enable: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_en |=> ($stable(dac_code) && $stable(busy) && $stable(sample_hold) && !done));
endmodule

bind sar_adc_ctrl sar_adc_ctrl_chk #(
    .DATA_W        (DATA_W),
    .SAMPLE_CYCLES (SAMPLE_CYCLES)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .clk_en      (clk_en),
    .start       (start),
    .cmp_in      (cmp_in),
    .sample_hold (sample_hold),
    .dac_code    (dac_code),
    .busy        (busy),
    .done        (done),
    .result      (result)
);

// File: tb/tb_sar_adc_ctrl.sv
`timescale 1ns/1ps
module tb_sar_adc_ctrl;
    localparam int W    = 8;
    localparam int S    = 2;
    localparam int MAXC = (1 << W) - 1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         clk_en = 1'b1;
    logic         start = 1'b0;
    logic         cmp_in;
    logic         sample_hold;
    logic [W-1:0] dac_code;
    logic         busy;
    logic         done;
    logic [W-1:0] result;

    int vin = 0;
    int en_period = 1;
    int div = 0;
    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    // Behavioural comparator: held input strictly above the DAC level
    assign cmp_in = (vin > int'(dac_code));

    // Prescaler model, driven away from the active edge
    always @(negedge clk) begin
        if (div >= en_period - 1) div = 0;
        else div = div + 1;
        clk_en = (div == 0);
    end

    sar_adc_ctrl #(.DATA_W(W), .SAMPLE_CYCLES(S)) dut (
        .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .start(start),
        .cmp_in(cmp_in), .sample_hold(sample_hold), .dac_code(dac_code),
        .busy(busy), .done(done), .result(result)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Largest code strictly below the input, saturating at the top code
    function automatic int expect_code(input int v);
        int e = 0;
        for (int c = 0; c <= MAXC; c++) if (v > c) e = c;
        return e;
    endfunction

    task automatic run_conv(input int v, input int p, input bit extra_start);
        int cycles = 0;
        int sh = 0;
        int first_code = -1;
        bit prev_sh;
        bit res_held = 1'b1;
        logic [W-1:0] old_res;
        old_res = result;
        vin = v;
        en_period = p;
        start = 1'b1;
        @(negedge clk);
        while (!busy) @(negedge clk);
        start = 1'b0;
        check(dac_code == '0, "R5 code zero while sampling", dac_code, 0);
        prev_sh = sample_hold;
        while (!done && cycles < 5000) begin
            if (sample_hold) sh++;
            if (result != old_res) res_held = 1'b0;
            if (extra_start) start = (cycles >= 2 && cycles <= 4);
            @(negedge clk);
            cycles++;
            if (prev_sh && !sample_hold && first_code < 0) first_code = dac_code;
            prev_sh = sample_hold;
        end
        start = 1'b0;
        check(cycles == (S + W) * p, extra_start ? "R7 restart ignored timing" : "R4/R9 conversion length",
              cycles, (S + W) * p);
        check(sh == S * p, "R5 sample phase length", sh, S * p);
        check(first_code == (1 << (W - 1)), "R1 first trial code", first_code, 1 << (W - 1));
        check(int'(result) == expect_code(v), "R2/R3 result", result, expect_code(v));
        check(!busy, "R6 busy low with done", busy, 0);
        check(res_held, "R8 result held until done", result, old_res);
        old_res = result;
        @(negedge clk);
        check(!done, "R6 done single cycle", done, 0);
        check(result == old_res, "R8 result stable after done", result, old_res);
    endtask

    initial begin
        int r;
        r = $urandom(32'd1234);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        check(!busy && !done && !sample_hold, "R10 reset flags", {busy, done, sample_hold}, 0);
        check(dac_code == '0, "R10 reset dac_code", dac_code, 0);
        check(result == '0, "R10 reset result", result, 0);
        // R9: start held off while enable stays low
        en_period = 1000;
        repeat (2) @(negedge clk);
        start = 1'b1;
        repeat (5) @(negedge clk);
        check(!busy, "R9 start needs enable", busy, 0);
        start = 1'b0;
        en_period = 1;
        repeat (2) @(negedge clk);
        // Directed corner inputs
        run_conv(0, 1, 1'b0);
        run_conv(1, 1, 1'b0);
        run_conv(128, 1, 1'b0);
        run_conv(255, 1, 1'b0);
        run_conv(256, 1, 1'b0);
        run_conv(900, 2, 1'b0);
        run_conv(77, 1, 1'b1);
        run_conv(200, 3, 1'b1);
        // Random inputs and enable periods
        for (int i = 0; i < 40; i++) begin
            run_conv(int'($urandom_range(0, 300)), int'($urandom_range(1, 4)), (i % 5) == 0);
        end
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule